// File: doc/BRIEF.md
# Window Framebuffer Fetch Address Generator

This block turns the programmed geometry of one overlay window into a stream of memory burst requests for the display fetch engine. A frame start pulse captures the base address, line pitch, width in pixels, height in lines and pixel format. The block then walks the window one line at a time. Each line's visible bytes (width times bytes per pixel) are cut into bursts of the selected size. The last burst of a line is cut to the bytes that remain, and the gap between the end of the visible bytes and the next pitch boundary is skipped.

Alongside the request stream the block presents the derived per-window values that the fetch and unpack stages consume: the address one pitch past the last line, a packed stride word (skip and visible bytes), the byte-swap mode implied by the format, and the burst size. The burst size is 16 words, or 8 words when the buffer is narrower than a threshold. Requests are gated by the window enable. When the last burst has been taken, a frame-done flag stays high until the next frame start.

Top module: `wfa_fetch_gen`

## Requirements
- R1: After reset `req_valid` and `frame_done` are low, and no request is made until a frame start is accepted.
- R2: A frame start seen while no walk is in progress is accepted. From the next cycle the first request carries `base_addr`.
- R3: The burst size is 64 bytes when `width_px` is 128 or more, and 32 bytes when it is below 128. `burst_bytes` shows this value after an accept.
- R4: Within a line the request addresses are contiguous. Every burst except the last one of the line has the full burst size. The last one carries the bytes that remain, which is never zero.
- R5: The first request of each line after the first sits exactly `pitch` bytes above the first request of the previous line, so the skip of pitch minus visible bytes is never fetched.
- R6: While `win_en` is low, `req_valid` is low and the walk does not move. A request that is offered and not taken stays unchanged in the next cycle.
- R7: After the last burst of the last line has been taken, `frame_done` is high and no request is made until the next frame start. A frame start that arrives during a walk is ignored.
- R8: `end_addr` equals base plus pitch times height, modulo 2^32.
- R9: Format codes 0 (1555) and 1 (565) use 2 bytes per pixel and `swap_mode` 2'b01 (halfword swap). Codes 2 (888 in a 32-bit word) and 3 (8888 with alpha) use 4 bytes per pixel and `swap_mode` 2'b10 (word swap).
- R10: With the default layout, `stride_word` holds the skip (pitch minus visible bytes) in bits 27:14 and the visible bytes per line in bits 13:0. The other bits are zero.
- R11: A frame start that is accepted with a width or height of zero makes no request. `frame_done` is high from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| win_en | input | 1 | Window enable; gates requests |
| frame_start | input | 1 | Frame start pulse; captures configuration |
| base_addr | input | 32 | Byte address of the first pixel |
| pitch | input | 16 | Bytes from one line start to the next |
| width_px | input | 12 | Window width in pixels |
| height | input | 12 | Window height in lines |
| fmt | input | 2 | Pixel format code |
| req_ready | input | 1 | Fetch engine takes the offered request |
| req_valid | output | 1 | A burst request is offered |
| req_addr | output | 32 | Byte address of the burst |
| req_len | output | 7 | Burst length in bytes |
| frame_done | output | 1 | Walk of the captured frame is complete |
| end_addr | output | 32 | Base plus pitch times height |
| stride_word | output | 32 | Packed skip and visible-byte fields |
| swap_mode | output | 2 | Byte-swap mode for the captured format |
| burst_bytes | output | 7 | Selected full burst size in bytes |

## Verification
The hardest case to reach from the ports is a stall that falls on the shortened last burst of a line while the window enable also drops. Here the walk must hold both its line base and its offset, and then step by exactly one pitch. The stimulus gets there by running widths that are not a multiple of the burst (150 and 127 pixels, among others) with a ready pattern derived from a free-running counter and a window enable that toggles on a different period. Over several lines these two patterns meet every line end. Boundary widths of 127 and 128 pixels test the burst choice, and a frame start sent during a walk tests that it is ignored.

// File: rtl/wfa_pkg.sv
package wfa_pkg;

  typedef enum logic [1:0] {
    FMT_X1555 = 2'd0,
    FMT_R565  = 2'd1,
    FMT_X888  = 2'd2,
    FMT_A8888 = 2'd3
  } pix_fmt_e;

  typedef enum logic [1:0] {
    SWP_NONE = 2'b00,
    SWP_HALF = 2'b01,
    SWP_WORD = 2'b10
  } swap_e;

  typedef enum logic [1:0] {
    WS_IDLE = 2'd0,
    WS_RUN  = 2'd1,
    WS_DONE = 2'd2
  } walk_st_e;

  // bytes per pixel as a shift amount (1 -> 2 bytes, 2 -> 4 bytes)
  function automatic logic [1:0] px_shift(input logic [1:0] f);
    return (f == FMT_X1555 || f == FMT_R565) ? 2'd1 : 2'd2;
  endfunction

  function automatic swap_e swap_for(input logic [1:0] f);
    return (f == FMT_X1555 || f == FMT_R565) ? SWP_HALF : SWP_WORD;
  endfunction

endpackage

// File: rtl/wfa_geom.sv
module wfa_geom
  import wfa_pkg::*;
#(
  parameter int AW           = 32,
  parameter int PW           = 16,
  parameter int WW           = 12,
  parameter int HW           = 12,
  parameter int NARROW_PX    = 128,
  parameter int WIDE_WORDS   = 16,
  parameter int NARROW_WORDS = 8,
  parameter bit WIDE_LAYOUT  = 1'b0,
  parameter int LBW          = WW + 2,
  parameter int BBW          = $clog2(WIDE_WORDS * 4 + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           load,
  input  logic [PW-1:0]  pitch_i,
  input  logic [AW-1:0]  base_i,
  input  logic [WW-1:0]  width_i,
  input  logic [HW-1:0]  height_i,
  input  logic [1:0]     fmt_i,
  output logic [LBW-1:0] line_bytes_o,
  output logic [PW-1:0]  pitch_o,
  output logic [HW-1:0]  height_o,
  output logic [BBW-1:0] burst_bytes_o,
  output logic [AW-1:0]  end_addr_o,
  output logic [31:0]    stride_word_o,
  output logic [1:0]     swap_o
);

  localparam int FULL_B   = WIDE_WORDS * 4;
  localparam int NARROW_B = NARROW_WORDS * 4;

  logic [AW-1:0]  base_q,  base_d;
  logic [PW-1:0]  pitch_q, pitch_d;
  logic [HW-1:0]  hgt_q,   hgt_d;
  logic [LBW-1:0] lb_q,    lb_d;
  logic [BBW-1:0] bb_q,    bb_d;
  logic [1:0]     swp_q,   swp_d;

  // next-state: capture on load only
  always_comb begin
    base_d  = base_q;
    pitch_d = pitch_q;
    hgt_d   = hgt_q;
    lb_d    = lb_q;
    bb_d    = bb_q;
    swp_d   = swp_q;
    if (load) begin
      base_d  = base_i;
      pitch_d = pitch_i;
      hgt_d   = height_i;
      lb_d    = LBW'(width_i) << px_shift(fmt_i);
      bb_d    = (32'(width_i) < NARROW_PX) ? BBW'(NARROW_B) : BBW'(FULL_B);
      swp_d   = swap_for(fmt_i);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q  <= '0;
      pitch_q <= '0;
      hgt_q   <= '0;
      lb_q    <= '0;
      bb_q    <= BBW'(FULL_B);
      swp_q   <= SWP_NONE;
    end else begin
      base_q  <= base_d;
      pitch_q <= pitch_d;
      hgt_q   <= hgt_d;
      lb_q    <= lb_d;
      bb_q    <= bb_d;
      swp_q   <= swp_d;
    end
  end

  logic [31:0] skip_ext;
  logic [31:0] lb_ext;
  assign skip_ext = 32'(pitch_q) - 32'(lb_q);
  assign lb_ext   = 32'(lb_q);

  generate
    if (WIDE_LAYOUT) begin : g_wide
      assign stride_word_o = {2'b00, skip_ext[14:0], lb_ext[14:0]};
    end else begin : g_norm
      assign stride_word_o = {4'b0000, skip_ext[13:0], lb_ext[13:0]};
    end
  endgenerate

  assign end_addr_o    = base_q + AW'(pitch_q) * AW'(hgt_q);
  assign line_bytes_o  = lb_q;
  assign pitch_o       = pitch_q;
  assign height_o      = hgt_q;
  assign burst_bytes_o = bb_q;
  assign swap_o        = swp_q;

  // R3
  burst_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (burst_bytes_o == BBW'(FULL_B)) || (burst_bytes_o == BBW'(NARROW_B)));

endmodule

// File: rtl/wfa_walker.sv
module wfa_walker
  import wfa_pkg::*;
#(
  parameter int AW  = 32,
  parameter int PW  = 16,
  parameter int HW  = 12,
  parameter int LBW = 14,
  parameter int BBW = 7
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           win_en,
  input  logic           frame_start,
  input  logic           req_ready,
  input  logic           cfg_empty,
  input  logic [AW-1:0]  base_i,
  input  logic [LBW-1:0] line_bytes_i,
  input  logic [PW-1:0]  pitch_i,
  input  logic [HW-1:0]  height_i,
  input  logic [BBW-1:0] burst_bytes_i,
  output logic           load_o,
  output logic           req_valid,
  output logic [AW-1:0]  req_addr,
  output logic [BBW-1:0] req_len,
  output logic           frame_done
);

  walk_st_e       st_q, st_d;
  logic [AW-1:0]  lbase_q, lbase_d;
  logic [LBW-1:0] off_q, off_d;
  logic [HW-1:0]  line_q, line_d;

  logic [LBW-1:0] remain;
  logic           tail;
  logic           last_line;
  logic           take;

  assign remain    = line_bytes_i - off_q;
  assign tail      = remain <= LBW'(burst_bytes_i);
  assign last_line = line_q == (height_i - HW'(1));
  assign load_o    = frame_start && (st_q != WS_RUN);
  assign req_valid = (st_q == WS_RUN) && win_en;
  assign take      = req_valid && req_ready;
  assign req_addr  = lbase_q + AW'(off_q);
  assign req_len   = tail ? BBW'(remain) : burst_bytes_i;
  assign frame_done = (st_q == WS_DONE);

  always_comb begin
    st_d    = st_q;
    lbase_d = lbase_q;
    off_d   = off_q;
    line_d  = line_q;
    if (load_o) begin
      st_d    = cfg_empty ? WS_DONE : WS_RUN;
      lbase_d = base_i;
      off_d   = '0;
      line_d  = '0;
    end else if (take) begin
      if (tail) begin
        off_d = '0;
        if (last_line) begin
          st_d = WS_DONE;
        end else begin
          lbase_d = lbase_q + AW'(pitch_i);
          line_d  = line_q + HW'(1);
        end
      end else begin
        off_d = off_q + LBW'(burst_bytes_i);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= WS_IDLE;
      lbase_q <= '0;
      off_q   <= '0;
      line_q  <= '0;
    end else begin
      st_q    <= st_d;
      lbase_q <= lbase_d;
      off_q   <= off_d;
      line_q  <= line_d;
    end
  end

  // R6
  win_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !win_en |-> !req_valid);

  // R6
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> $stable(req_addr) && $stable(req_len));

  // R4
  len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_len != '0) && (req_len <= burst_bytes_i));

  // R7
  done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done && !frame_start |=> frame_done);

  // R7
  done_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> !req_valid);

endmodule

// File: rtl/wfa_fetch_gen.sv
module wfa_fetch_gen
  import wfa_pkg::*;
#(
  parameter int AW           = 32,
  parameter int PW           = 16,
  parameter int WW           = 12,
  parameter int HW           = 12,
  parameter int NARROW_PX    = 128,
  parameter int WIDE_WORDS   = 16,
  parameter int NARROW_WORDS = 8,
  parameter bit WIDE_LAYOUT  = 1'b0,
  localparam int LBW         = WW + 2,
  localparam int BBW         = $clog2(WIDE_WORDS * 4 + 1)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           win_en,
  input  logic           frame_start,
  input  logic [AW-1:0]  base_addr,
  input  logic [PW-1:0]  pitch,
  input  logic [WW-1:0]  width_px,
  input  logic [HW-1:0]  height,
  input  logic [1:0]     fmt,
  input  logic           req_ready,
  output logic           req_valid,
  output logic [AW-1:0]  req_addr,
  output logic [BBW-1:0] req_len,
  output logic           frame_done,
  output logic [AW-1:0]  end_addr,
  output logic [31:0]    stride_word,
  output logic [1:0]     swap_mode,
  output logic [BBW-1:0] burst_bytes
);

  logic           load;
  logic [LBW-1:0] line_bytes;
  logic [PW-1:0]  pitch_r;
  logic [HW-1:0]  height_r;
  logic           cfg_empty;

  assign cfg_empty = (width_px == '0) || (height == '0);

  wfa_geom #(
    .AW(AW), .PW(PW), .WW(WW), .HW(HW), .NARROW_PX(NARROW_PX),
    .WIDE_WORDS(WIDE_WORDS), .NARROW_WORDS(NARROW_WORDS),
    .WIDE_LAYOUT(WIDE_LAYOUT), .LBW(LBW), .BBW(BBW)
  ) u_geom (
    .clk          (clk),
    .rst_n        (rst_n),
    .load         (load),
    .pitch_i      (pitch),
    .base_i       (base_addr),
    .width_i      (width_px),
    .height_i     (height),
    .fmt_i        (fmt),
    .line_bytes_o (line_bytes),
    .pitch_o      (pitch_r),
    .height_o     (height_r),
    .burst_bytes_o(burst_bytes),
    .end_addr_o   (end_addr),
    .stride_word_o(stride_word),
    .swap_o       (swap_mode)
  );

  wfa_walker #(
    .AW(AW), .PW(PW), .HW(HW), .LBW(LBW), .BBW(BBW)
  ) u_walk (
    .clk          (clk),
    .rst_n        (rst_n),
    .win_en       (win_en),
    .frame_start  (frame_start),
    .req_ready    (req_ready),
    .cfg_empty    (cfg_empty),
    .base_i       (base_addr),
    .line_bytes_i (line_bytes),
    .pitch_i      (pitch_r),
    .height_i     (height_r),
    .burst_bytes_i(burst_bytes),
    .load_o       (load),
    .req_valid    (req_valid),
    .req_addr     (req_addr),
    .req_len      (req_len),
    .frame_done   (frame_done)
  );

  // R11
  empty_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load && cfg_empty |=> frame_done && !req_valid);

endmodule

// File: tb/sim_wfa_fetch_gen.sv
module sim_wfa_fetch_gen;

  localparam int CLK_P = 10;

  logic        clk;
  logic        rst_n;
  logic        win_en;
  logic        frame_start;
  logic [31:0] base_addr;
  logic [15:0] pitch;
  logic [11:0] width_px;
  logic [11:0] height;
  logic [1:0]  fmt;
  logic        req_ready;
  logic        req_valid;
  logic [31:0] req_addr;
  logic [6:0]  req_len;
  logic        frame_done;
  logic [31:0] end_addr;
  logic [31:0] stride_word;
  logic [1:0]  swap_mode;
  logic [6:0]  burst_bytes;

  wfa_fetch_gen u0 (
    .clk(clk), .rst_n(rst_n), .win_en(win_en), .frame_start(frame_start),
    .base_addr(base_addr), .pitch(pitch), .width_px(width_px),
    .height(height), .fmt(fmt), .req_ready(req_ready),
    .req_valid(req_valid), .req_addr(req_addr), .req_len(req_len),
    .frame_done(frame_done), .end_addr(end_addr),
    .stride_word(stride_word), .swap_mode(swap_mode),
    .burst_bytes(burst_bytes)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  int checks = 0;
  int errors = 0;

  // behavioural reference model
  int unsigned q_addr[$];
  int unsigned q_len[$];
  bit          m_run  = 0;
  bit          m_done = 0;
  bit          m_cfg  = 0;
  int unsigned e_end, e_stride, e_swap, e_burst;

  // stimulus pattern controls
  int  rdy_mode = 0;   // 0: always ready, 1: counter pattern
  int  en_mode  = 0;   // 0: always enabled, 1: toggling
  int  cyc      = 0;

  task automatic build_frame();
    int bpp, lb, bb;
    bpp = (fmt < 2) ? 2 : 4;                 // R9
    lb  = int'(width_px) * bpp;
    bb  = (width_px < 128) ? 32 : 64;        // R3
    q_addr.delete();
    q_len.delete();
    for (int l = 0; l < int'(height); l++) begin
      int off;
      off = 0;
      while (off < lb) begin
        int n;
        n = (lb - off < bb) ? lb - off : bb; // R4
        q_addr.push_back(base_addr + l * pitch + off); // R5
        q_len.push_back(n);
        off += n;
      end
    end
    e_end    = base_addr + int'(pitch) * int'(height); // R8
    e_stride = (((int'(pitch) - lb) & 32'h3fff) << 14) | (lb & 32'h3fff); // R10
    e_swap   = (fmt < 2) ? 1 : 2;
    e_burst  = bb;
    m_cfg    = 1;
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_run = 0; m_done = 0; m_cfg = 0;
      q_addr.delete(); q_len.delete();
    end else begin
      bit was_run;
      was_run = m_run;
      if (was_run && win_en && req_ready && q_addr.size() > 0) begin
        void'(q_addr.pop_front());
        void'(q_len.pop_front());
        if (q_addr.size() == 0) begin m_run = 0; m_done = 1; end
      end
      if (!was_run && frame_start) begin  // R2 R7
        build_frame();
        if (q_addr.size() == 0) begin m_run = 0; m_done = 1; end  // R11
        else begin m_run = 1; m_done = 0; end
      end
    end
  end

  task automatic chk(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare a quarter period after each rising edge
  always begin
    @(posedge clk);
    #(CLK_P/4);
    if (rst_n) begin
      bit ev;
      ev = m_run && win_en;
      chk("R6 R7 req_valid", req_valid, ev);
      chk("R7 R11 frame_done", frame_done, m_done);
      if (ev && req_valid) begin
        chk("R2 R4 R5 req_addr", req_addr, q_addr[0]);
        chk("R3 R4 req_len", req_len, q_len[0]);
      end
      if (m_cfg) begin
        chk("R8 end_addr", end_addr, e_end);
        chk("R10 stride_word", stride_word, e_stride);
        chk("R9 swap_mode", swap_mode, e_swap);
        chk("R3 burst_bytes", burst_bytes, e_burst);
      end
    end
  end

  // pattern drivers on the falling edge
  always @(negedge clk) begin
    cyc++;
    req_ready <= (rdy_mode == 0) ? 1'b1 : ((cyc % 5) != 2 && (cyc % 7) != 0);
    win_en    <= (en_mode == 0) ? 1'b1 : ((cyc % 11) < 8);
  end

  task automatic start_frame(input int b, input int p, input int w,
                             input int h, input int f);
    @(negedge clk);
    base_addr   = b;
    pitch       = 16'(p);
    width_px    = 12'(w);
    height      = 12'(h);
    fmt         = 2'(f);
    frame_start = 1'b1;
    @(negedge clk);
    frame_start = 1'b0;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (frame_done) break;
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    rst_n = 1'b0; frame_start = 1'b0; win_en = 1'b1; req_ready = 1'b1;
    base_addr = '0; pitch = '0; width_px = '0; height = '0; fmt = '0;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 req_valid at reset", req_valid, 0);
    chk("R1 frame_done at reset", frame_done, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle after reset", req_valid, 0);

    // wide 8888 window, ready always: 600 bytes per line, tail 24
    start_frame(32'h0000_1000, 800, 150, 3, 3);
    wait_done();
    // R7: stays done and quiet
    repeat (6) @(negedge clk);
    chk("R7 done held", frame_done, 1);

    // narrow 1555 window with stalls and enable gaps (R6)
    rdy_mode = 1; en_mode = 1;
    start_frame(32'h2000_0040, 256, 100, 4, 0);
    // R7: frame start during a walk is ignored
    repeat (5) @(negedge clk);
    start_frame(32'h7777_0000, 64, 10, 1, 1);
    wait_done();

    // boundary widths for R3: 127 px 565, then 128 px 888
    start_frame(32'h0001_0002, 300, 127, 3, 1);
    wait_done();
    start_frame(32'h0003_0000, 1024, 128, 3, 2);
    wait_done();

    // R11: zero height, then zero width
    start_frame(32'h0004_0000, 128, 20, 0, 3);
    repeat (3) @(negedge clk);
    chk("R11 zero height done", frame_done, 1);
    start_frame(32'h0005_0000, 128, 0, 5, 0);
    repeat (3) @(negedge clk);
    chk("R11 zero width done", frame_done, 1);

    // end address wrap R8, large pitch
    rdy_mode = 0; en_mode = 1;
    start_frame(32'hFFFF_F000, 4000, 33, 5, 2);
    wait_done();

    summary();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

endmodule